// File: doc/BRIEF.md
# Latched Vectored Interrupt Controller

This block sits on the bus side of a digital input card. It watches a set of external interrupt lines and detects an edge on each one, using a polarity that is set per line. Each edge is caught in a latch for that line. A software mask decides which latched lines count as pending. When the global enable is on and any line is pending, the block drives one backplane request line. The request level is chosen by a 3-bit level input.

Software uses a small register bus. It programs the mask, the handler vector and the enable. It reads the pending lines and a summary flag. It clears serviced lines by writing ones to the clear register. An acknowledge strobe makes the block return the vector on the read data bus. The request is not dropped by the acknowledge. It stays up until software clears the latches behind it, masks them out, or turns the enable off. An edge that arrives while the enable is off stays latched and raises the request once the enable is set.

Top module: `lvic_top`

## Requirements
- R1: Each input line has its own latch, set by a rising edge when its polarity bit is 1 and by a falling edge when it is 0. The opposite edge does nothing, and a set latch stays set until it is cleared.
- R2: Reading offset 2 returns the latches ANDed with the mask register at offset 1, where a mask bit of 1 enables that line. A latch that is masked off is kept, and it shows up as soon as its mask bit is set.
- R3: Bit 3 of the control register at offset 0 is the global enable. While it is 0, all request lines stay low.
- R4: A line that is latched and unmasked while the enable is 0 stays pending. Setting the enable then raises the request. Clearing that line's mask bit drops the request, and setting the mask bit again restores it.
- R5: Bit 2 of the control register reads 1 exactly when any latched line is unmasked, whatever the enable is. Writes do not change it, and the other control bits read 0. Read data appears on the clock edge after the read strobe.
- R6: A write to offset 2 clears the latch of every line whose data bit is 1. Lines whose data bit is 0 keep their state.
- R7: An acknowledge strobe does not change the request. The request stays up until a clear write, a mask write or a disable removes the last pending line.
- R8: The request output is one-hot. For level L from 1 to 7, bit L-1 is driven, and level 0 drives no line.
- R9: The vector register at offset 3 reads back what was written. One cycle after an acknowledge strobe, the read data holds the vector.
- R10: Reset clears the enable and the read data, so no request is driven. The latches, the mask and the vector are undefined after reset, and software must program them.
- R11: When an edge on a line arrives in the same cycle as a clear of that line, the edge wins and the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or vector |
| irq_in | input | 8 | External interrupt lines, synchronous to clk |
| edge_pol | input | 8 | Per-line polarity, 1 = rising, 0 = falling |
| level_sel | input | 3 | Request level, 0 = none |
| iack | input | 1 | Acknowledge strobe |
| req_lines | output | 7 | One-hot backplane request, bit L-1 for level L |

## Verification
The assertions assume that the interrupt lines are already synchronous to the clock. They also assume that write, read and acknowledge strobes last one cycle each, and that the level input changes only while the bench is sweeping levels. The stimulus drives every input on the falling clock edge and pulses each strobe for exactly one cycle. The bench clears all latches and programs the vector before it sets the enable, so no check depends on the undefined contents those registers have after reset.

// File: rtl/ivc_pkg.sv
// Shared register offsets and control bit positions for the interrupt controller.
// Assumes a 2-bit word offset on the register bus.
package ivc_pkg;
    localparam int ADDR_W        = 2;
    localparam int CTRL_EN_BIT   = 3;
    localparam int CTRL_PEND_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_MASK = 2'd1,
        REG_PEND = 2'd2,
        REG_VEC  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ivc_edge_latch.sv
// Per-line edge detector and sticky latch.
// Assumes the input lines are already synchronous to clk. The latches are not
// reset on purpose: software clears them before it enables interrupts.
module ivc_edge_latch #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] edge_pol,
    input  logic [N_LINES-1:0] clr_mask,
    output logic [N_LINES-1:0] latch_q
);
    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] evt;

    // Keep the last sample of every line for edge detection.
    always_ff @(posedge clk) begin
        prev_q <= irq_in;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        // Pick the edge each line reacts to, from its polarity bit.
        always_comb begin
            if (edge_pol[i]) evt[i] = irq_in[i] & ~prev_q[i];
            else             evt[i] = ~irq_in[i] & prev_q[i];
        end

        // Set the latch on an event; a clear only takes effect when no event arrives.
        always_ff @(posedge clk) begin
            latch_q[i] <= evt[i] | (latch_q[i] & ~clr_mask[i]);
        end
    end
endmodule

// File: rtl/ivc_regfile.sv
// Software-visible registers: control, mask, clear/pending and vector.
// Assumes one-cycle strobes. Read data is registered, and an acknowledge takes
// priority over a read.
module ivc_regfile
    import ivc_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               iack,
    input  logic [N_LINES-1:0] pend_vec,
    output logic [DATA_W-1:0]  rdata,
    output logic [N_LINES-1:0] mask_q,
    output logic [DATA_W-1:0]  vec_q,
    output logic               en_q,
    output logic [N_LINES-1:0] clr_mask
);
    logic [DATA_W-1:0] rd_mux;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(addr);

    // Clear pulses come straight from the write data of a clear-register write.
    assign clr_mask = (wr_en && sel == REG_PEND) ? wdata[N_LINES-1:0] : '0;

    // Global enable; reset turns it off.
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= 1'b0;
        else if (wr_en && sel == REG_CTRL) en_q <= wdata[CTRL_EN_BIT];
    end

    // Mask and vector are left undefined by reset; software programs them.
    always_ff @(posedge clk) begin
        if (wr_en && sel == REG_MASK) mask_q <= wdata[N_LINES-1:0];
        if (wr_en && sel == REG_VEC)  vec_q  <= wdata;
    end

    // Select the register being read.
    always_comb begin
        rd_mux = '0;
        case (sel)
            REG_CTRL: begin
                rd_mux[CTRL_EN_BIT]   = en_q;
                rd_mux[CTRL_PEND_BIT] = |pend_vec;
            end
            REG_MASK: rd_mux = DATA_W'(mask_q);
            REG_PEND: rd_mux = DATA_W'(pend_vec);
            REG_VEC:  rd_mux = vec_q;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data; an acknowledge returns the vector.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (iack)  rdata <= vec_q;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/ivc_request.sv
// Turns the pending summary into a one-hot request at the selected level.
// Assumes level 0 means no line is driven.
module ivc_request #(
    parameter int LVL_W = 3
) (
    input  logic                      en,
    input  logic                      pend_any,
    input  logic [LVL_W-1:0]          level_sel,
    output logic [(1<<LVL_W)-2:0]     req_lines
);
    localparam int N_LVL = (1 << LVL_W) - 1;

    for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
        // Drive this level's line when it is selected and a request is live.
        always_comb begin
            req_lines[k] = en & pend_any & (level_sel == LVL_W'(k + 1));
        end
    end
endmodule

// File: rtl/lvic_top.sv
// Latched vectored interrupt controller: edge latches, mask, enable,
// level-selected request and vector return on acknowledge.
// Assumes inputs are synchronous to clk and strobes last one cycle.
module lvic_top
    import ivc_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8,
    parameter int LVL_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [N_LINES-1:0]    irq_in,
    input  logic [N_LINES-1:0]    edge_pol,
    input  logic [LVL_W-1:0]      level_sel,
    input  logic                  iack,
    output logic [(1<<LVL_W)-2:0] req_lines
);
    logic [N_LINES-1:0] latch_q;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] clr_mask;
    logic [N_LINES-1:0] pend_vec;
    logic [DATA_W-1:0]  vec_q;
    logic               en_q;

    // Only unmasked latches are pending.
    assign pend_vec = latch_q & mask_q;

    ivc_edge_latch #(.N_LINES(N_LINES)) u_latch (
        .clk      (clk),
        .irq_in   (irq_in),
        .edge_pol (edge_pol),
        .clr_mask (clr_mask),
        .latch_q  (latch_q)
    );

    ivc_regfile #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .iack     (iack),
        .pend_vec (pend_vec),
        .rdata    (rdata),
        .mask_q   (mask_q),
        .vec_q    (vec_q),
        .en_q     (en_q),
        .clr_mask (clr_mask)
    );

    ivc_request #(.LVL_W(LVL_W)) u_req (
        .en        (en_q),
        .pend_any  (|pend_vec),
        .level_sel (level_sel),
        .req_lines (req_lines)
    );
endmodule

// File: rtl/lvic_checker.sv
// Temporal checks on the interrupt controller, attached by bind.
module lvic_checker #(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8,
    parameter int LVL_W   = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [1:0]            addr,
    input logic                  iack,
    input logic [LVL_W-1:0]      level_sel,
    input logic [DATA_W-1:0]     rdata,
    input logic [(1<<LVL_W)-2:0] req_lines,
    input logic [N_LINES-1:0]    latch_q,
    input logic [DATA_W-1:0]     vec_q,
    input logic                  en_q
);
    // R3
    no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> req_lines == '0);

    // R8
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_lines));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lines != '0 && !wr_en && level_sel != '0 && $stable(level_sel))
        |=> (req_lines != '0 || level_sel != $past(level_sel)));

    // R1
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd2) |=> ((($past(latch_q)) & ~latch_q) == '0));

    // R9
    ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack |=> rdata == $past(vec_q));
endmodule

bind lvic_top lvic_checker #(.N_LINES(N_LINES), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .iack      (iack),
    .level_sel (level_sel),
    .rdata     (rdata),
    .req_lines (req_lines),
    .latch_q   (latch_q),
    .vec_q     (vec_q),
    .en_q      (en_q)
);

// File: tb/test_lvic_top.sv
module test_lvic_top;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IN = 2'd2, OP_REQ = 2'd3;
    localparam logic [1:0] A_CTRL = 2'd0, A_MASK = 2'd1, A_PEND = 2'd2, A_VEC = 2'd3;
    localparam int N_TBL = 25;

    // {op, addr, data, expected, requirement number}
    localparam logic [23:0] TBL [N_TBL] = '{
        {OP_WR,  A_PEND, 8'hFF, 8'h00, 4'd6},  // R6 clear all latches
        {OP_WR,  A_VEC,  8'hA5, 8'h00, 4'd9},  // R9
        {OP_RD,  A_VEC,  8'h00, 8'hA5, 4'd9},  // R9
        {OP_WR,  A_MASK, 8'h0F, 8'h00, 4'd2},  // R2
        {OP_RD,  A_CTRL, 8'h00, 8'h00, 4'd5},  // R5
        {OP_IN,  2'd0,   8'hF1, 8'h00, 4'd1},  // R1 line0 rises
        {OP_RD,  A_PEND, 8'h00, 8'h01, 4'd1},  // R1
        {OP_RD,  A_CTRL, 8'h00, 8'h04, 4'd5},  // R5 flag while disabled
        {OP_REQ, 2'd0,   8'h00, 8'h00, 4'd3},  // R3
        {OP_IN,  2'd0,   8'hF0, 8'h00, 4'd1},  // R1 wrong edge
        {OP_IN,  2'd0,   8'h70, 8'h00, 4'd2},  // R2 line7 falls, masked
        {OP_RD,  A_PEND, 8'h00, 8'h01, 4'd2},  // R2
        {OP_WR,  A_MASK, 8'h8F, 8'h00, 4'd2},  // R2
        {OP_RD,  A_PEND, 8'h00, 8'h81, 4'd2},  // R2 masked latch kept
        {OP_WR,  A_CTRL, 8'h08, 8'h00, 4'd3},  // R3
        {OP_RD,  A_CTRL, 8'h00, 8'h0C, 4'd3},  // R3
        {OP_REQ, 2'd0,   8'h00, 8'h04, 4'd8},  // R8 level 3
        {OP_WR,  A_PEND, 8'h01, 8'h00, 4'd6},  // R6
        {OP_RD,  A_PEND, 8'h00, 8'h80, 4'd6},  // R6
        {OP_REQ, 2'd0,   8'h00, 8'h04, 4'd7},  // R7
        {OP_WR,  A_PEND, 8'h80, 8'h00, 4'd6},  // R6
        {OP_RD,  A_CTRL, 8'h00, 8'h08, 4'd5},  // R5
        {OP_REQ, 2'd0,   8'h00, 8'h00, 4'd6},  // R6
        {OP_IN,  2'd0,   8'hF0, 8'h00, 4'd1},  // R1 line7 rises, no event
        {OP_RD,  A_PEND, 8'h00, 8'h00, 4'd1}   // R1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, iack = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'hF0;
    logic [7:0] edge_pol = 8'h0F;
    logic [2:0] level_sel = 3'd3;
    logic [6:0] req_lines;
    int total = 0, bad = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    lvic_top i_lvic_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .edge_pol(edge_pol),
        .level_sel(level_sel), .iack(iack), .req_lines(req_lines)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic drive_in(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rdata", rdata, 8'h00);
        check("R10 req", {1'b0, req_lines}, 8'h00);
        rst_n = 1'b1;
        bus_rd(A_CTRL, rv);
        check("R10 enable", rv & 8'h08, 8'h00);

        for (int i = 0; i < N_TBL; i++) begin
            logic [1:0] op, a;
            logic [7:0] d, e;
            string tag;
            {op, a, d, e} = TBL[i][23:4];
            tag = $sformatf("R%0d step%0d", TBL[i][3:0], i);
            case (op)
                OP_WR:  bus_wr(a, d);
                OP_RD:  begin bus_rd(a, rv); check(tag, rv, e); end
                OP_IN:  drive_in(d);
                default: check(tag, {1'b0, req_lines}, e);
            endcase
        end

        // R7 / R9: acknowledge returns vector and leaves request up
        drive_in(8'hF2);
        check("R7 req before ack", {1'b0, req_lines}, 8'h04);
        @(negedge clk); iack = 1'b1;
        @(negedge clk); iack = 1'b0;
        check("R9 ack vector", rdata, 8'hA5);
        check("R7 req after ack", {1'b0, req_lines}, 8'h04);
        @(negedge clk);
        check("R7 req later", {1'b0, req_lines}, 8'h04);
        drive_in(8'hF0);

        // R11: edge and clear of the same line in one cycle
        @(negedge clk); wr_en = 1'b1; addr = A_PEND; wdata = 8'h02; irq_in = 8'hF2;
        @(negedge clk); wr_en = 1'b0;
        bus_rd(A_PEND, rv);
        check("R11 edge beats clear", rv, 8'h02);
        bus_wr(A_PEND, 8'h02);
        bus_rd(A_PEND, rv);
        check("R6 clear without edge", rv, 8'h00);
        drive_in(8'hF0);

        // R4: event while disabled is held, mask-out drops it
        bus_wr(A_CTRL, 8'h00);
        drive_in(8'hF4);
        check("R4 no req disabled", {1'b0, req_lines}, 8'h00);
        bus_rd(A_CTRL, rv);
        check("R4 pending held", rv, 8'h04);
        bus_wr(A_CTRL, 8'h08);
        check("R4 req on enable", {1'b0, req_lines}, 8'h04);
        bus_wr(A_MASK, 8'h8B);
        check("R4 masked out", {1'b0, req_lines}, 8'h00);
        bus_wr(A_MASK, 8'h8F);
        check("R4 mask restored", {1'b0, req_lines}, 8'h04);

        // R8: level sweep
        for (int lv = 0; lv < 8; lv++) begin
            @(negedge clk); level_sel = 3'(lv);
            @(negedge clk);
            check($sformatf("R8 level %0d", lv), {1'b0, req_lines},
                  (lv == 0) ? 8'h00 : 8'(1 << (lv - 1)));
        end
        level_sel = 3'd3;

        // R10: reset while a request is live
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10 req in reset", {1'b0, req_lines}, 8'h00);
        rst_n = 1'b1;
        bus_rd(A_CTRL, rv);
        check("R10 enable after reset", rv & 8'h08, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule